// File: doc/BRIEF.md
# Pulse Period and Width Capture

This block watches one asynchronous digital input and measures its waveform in system clock cycles. The input is passed through a synchroniser and an edge detector. A saturating counter restarts on every rising edge. Its value at the next rising edge becomes the period, and its value at the falling edge in between becomes the high time, or pulse width. Each new value is placed on a result port together with a one-cycle strobe of its own, so that a downstream consumer can move it without polling.

The block also watches for a missing signal. A second saturating counter counts the cycles since the last rising edge. When that count reaches a programmable timeout, the block reports zero frequency: it clears both results and the valid flag, raises a no-signal flag, and shows on a level flag whether the input is stuck low or stuck high. Once a proper periodic signal returns, the first rising edge only re-arms the measurement. Results resume from the next complete period onward, so an old measurement is never shown as current.

Top module: `pulse_capture`

## Requirements
- R1: During and right after reset, every output is zero: both results, both strobes, the valid flag, the no-signal flag and the level flag.
- R2: Let successive rising edges of the input be P cycles apart. The period output then takes the value P, and the period strobe is high for that one cycle. This holds for every edge except the first one after arming.
- R3: Let the input stay high for H cycles after a rising edge. The width output then takes the value H at the falling edge, and the width strobe is high for one cycle. Every falling edge after an arming rising edge produces a width update.
- R4: Each strobe is a single-cycle pulse and is never high on two consecutive cycles.
- R5: The valid flag is high only while a complete period and width pair has been captured since the last reset or timeout. It is never high together with the no-signal flag.
- R6: The first rising edge after reset or after a timeout produces no period strobe and leaves the period output at zero.
- R7: If no rising edge occurs for `timeout_i` cycles while the input is low, the block sets the no-signal flag to 1 and the level flag to 0. It also forces the period and width outputs to zero and clears the valid flag.
- R8: If no rising edge occurs for `timeout_i` cycles while the input is high, the block sets the no-signal flag to 1 and the level flag to 1. Both results are zero and the valid flag is clear.
- R9: A period of exactly `timeout_i` cycles is measured normally and does not time out. A period of `timeout_i`+1 cycles always times out, so no period is ever reported.
- R10: Both count registers stop at 2^CNT_W-1 and never wrap. A period or high time longer than that reads as 2^CNT_W-1.
- R11: After a timeout, the first captured period clears the no-signal and level flags and sets the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all counts are in its cycles |
| rst_ni | input | 1 | Active-low synchronous reset |
| sig_i | input | 1 | Asynchronous waveform to measure |
| timeout_i | input | TMO_W | Cycles without a rising edge before the no-signal flag is set |
| period_o | output | CNT_W | Last captured rise-to-rise period, zero when no signal |
| width_o | output | CNT_W | Last captured high time, zero when no signal |
| period_stb_o | output | 1 | One-cycle pulse when period_o is updated |
| width_stb_o | output | 1 | One-cycle pulse when width_o is updated |
| valid_o | output | 1 | A full period and width pair is present |
| nosig_o | output | 1 | Timeout has occurred since the last captured period |
| level_o | output | 1 | Input level at timeout: 0 stuck low, 1 stuck high |

## Verification
The bench sweeps high and low times from one cycle upward. A design that is off by one in the counter restart, or that measures at the wrong synchroniser stage, would show a constant offset on every entry. At the timeout boundary it drives periods of exactly the timeout and of one cycle more. Placing the comparison on the wrong side of equality would either reject the legal period or accept the illegal one. The bench also drives stuck-low, stuck-high and re-arming sequences. These catch a design that keeps stale results, inverts the level flag, or reports a period on the arming edge. A run with high times longer than the counter range exposes a counter that wraps instead of saturating: it would report a small, plausible value.

// File: rtl/pc_pkg.sv
package pc_pkg;

    // Measurement sequencing: waiting for an arming edge, armed, running.
    typedef enum logic [1:0] {
        CAP_WAIT  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_RUN   = 2'd2
    } cap_state_e;

    localparam int unsigned DEF_CNT_W  = 32;
    localparam int unsigned DEF_TMO_W  = 32;
    localparam int unsigned DEF_STAGES = 2;

endpackage

// File: rtl/pc_sync_edge.sv
module pc_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    // STAGES synchroniser flops plus one history flop for edge detection.
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d;
    logic [CHAIN_W-1:0] chain_q;

    generate
        for (genvar g = 0; g < CHAIN_W; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign chain_d[g] = async_i;
            end else begin : g_next
                assign chain_d[g] = chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o  = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/pc_sat_counter.sv
module pc_sat_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         restart_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = W'(1);

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    // A restart loads one so that the count equals the cycles since the edge.
    always_comb begin
        if (restart_i) begin
            cnt_d = CNT_ONE;
        end else if (cnt_q == CNT_MAX) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + CNT_ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/pulse_capture.sv
module pulse_capture
    import pc_pkg::*;
#(
    parameter int unsigned CNT_W       = DEF_CNT_W,
    parameter int unsigned TMO_W       = DEF_TMO_W,
    parameter int unsigned SYNC_STAGES = DEF_STAGES
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sig_i,
    input  logic [TMO_W-1:0] timeout_i,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] width_o,
    output logic             period_stb_o,
    output logic             width_stb_o,
    output logic             valid_o,
    output logic             nosig_o,
    output logic             level_o
);
    localparam logic [CNT_W-1:0] RES_ZERO = '0;

    typedef struct packed {
        cap_state_e       state;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] width;
        logic             pstb;
        logic             wstb;
        logic             valid;
        logic             nosig;
        logic             level;
    } cap_reg_t;

    localparam cap_reg_t CAP_RESET = '{
        state:  CAP_WAIT,
        period: RES_ZERO,
        width:  RES_ZERO,
        pstb:   1'b0,
        wstb:   1'b0,
        valid:  1'b0,
        nosig:  1'b0,
        level:  1'b0
    };

    logic             sync_level;
    logic             sync_rise;
    logic             sync_fall;
    logic [CNT_W-1:0] edge_cnt;
    logic [TMO_W-1:0] idle_cnt;
    logic             timeout_hit;

    cap_reg_t r_d;
    cap_reg_t r_q;

    pc_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (sig_i),
        .level_o (sync_level),
        .rise_o  (sync_rise),
        .fall_o  (sync_fall)
    );

    // Measures the waveform: cycles since the last rising edge.
    pc_sat_counter #(
        .W (CNT_W)
    ) i_edge_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (sync_rise),
        .count_o   (edge_cnt)
    );

    // Watches for a missing signal, sized by the timeout range.
    pc_sat_counter #(
        .W (TMO_W)
    ) i_idle_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (sync_rise),
        .count_o   (idle_cnt)
    );

    // A rising edge in the very cycle the limit is reached still counts.
    assign timeout_hit = (idle_cnt >= timeout_i) && !sync_rise;

    always_comb begin
        r_d      = r_q;
        r_d.pstb = 1'b0;
        r_d.wstb = 1'b0;

        if (sync_rise) begin
            if (r_q.state == CAP_WAIT) begin
                r_d.state = CAP_ARMED;
            end else begin
                r_d.state  = CAP_RUN;
                r_d.period = edge_cnt;
                r_d.pstb   = 1'b1;
                r_d.valid  = 1'b1;
                r_d.nosig  = 1'b0;
                r_d.level  = 1'b0;
            end
        end else if (timeout_hit) begin
            r_d.state  = CAP_WAIT;
            r_d.period = RES_ZERO;
            r_d.width  = RES_ZERO;
            r_d.valid  = 1'b0;
            r_d.nosig  = 1'b1;
            r_d.level  = sync_level;
        end else if (sync_fall && (r_q.state != CAP_WAIT)) begin
            r_d.width = edge_cnt;
            r_d.wstb  = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= CAP_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign period_o     = r_q.period;
    assign width_o      = r_q.width;
    assign period_stb_o = r_q.pstb;
    assign width_stb_o  = r_q.wstb;
    assign valid_o      = r_q.valid;
    assign nosig_o      = r_q.nosig;
    assign level_o      = r_q.level;

endmodule

// File: rtl/pc_capture_checks.sv
module pc_capture_checks #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CNT_W-1:0] period_o,
    input logic [CNT_W-1:0] width_o,
    input logic             period_stb_o,
    input logic             width_stb_o,
    input logic             valid_o,
    input logic             nosig_o,
    input logic             level_o
);
    a_r4_period_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_stb_o |=> !period_stb_o);

    a_r4_width_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        width_stb_o |=> !width_stb_o);

    a_r5_valid_excludes_nosig: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> !nosig_o);

    a_r2_stb_marks_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_stb_o |-> (valid_o && period_o != '0));

    a_r7_nosig_zero_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nosig_o |-> (period_o == '0));

    a_r8_level_needs_nosig: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_o |-> nosig_o);

    a_r3_width_within_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        period_stb_o |-> (width_o <= period_o));

    a_r6_stb_needs_history: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_stb_o && $past(!valid_o)) |-> $past(period_o == '0));

endmodule

bind pulse_capture pc_capture_checks #(.CNT_W(CNT_W)) i_checks (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_o     (period_o),
    .width_o      (width_o),
    .period_stb_o (period_stb_o),
    .width_stb_o  (width_stb_o),
    .valid_o      (valid_o),
    .nosig_o      (nosig_o),
    .level_o      (level_o)
);

// File: tb/test_pulse_capture.sv
module test_pulse_capture;
    localparam int unsigned CNT_W = 8;
    localparam int unsigned TMO_W = 12;
    localparam int unsigned T_STD = 40;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             sig_i = 1'b0;
    logic [TMO_W-1:0] timeout_i = TMO_W'(T_STD);
    logic [CNT_W-1:0] period_o;
    logic [CNT_W-1:0] width_o;
    logic             period_stb_o;
    logic             width_stb_o;
    logic             valid_o;
    logic             nosig_o;
    logic             level_o;

    int checks = 0;
    int errors = 0;
    int pstb_cnt = 0;
    int wstb_cnt = 0;
    int dbl_cnt = 0;
    logic pstb_prev = 1'b0;
    logic wstb_prev = 1'b0;

    always #2.5 clk_i = ~clk_i;

    pulse_capture #(
        .CNT_W       (CNT_W),
        .TMO_W       (TMO_W),
        .SYNC_STAGES (2)
    ) i_pulse_capture (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sig_i        (sig_i),
        .timeout_i    (timeout_i),
        .period_o     (period_o),
        .width_o      (width_o),
        .period_stb_o (period_stb_o),
        .width_stb_o  (width_stb_o),
        .valid_o      (valid_o),
        .nosig_o      (nosig_o),
        .level_o      (level_o)
    );

    always @(negedge clk_i) begin
        if (period_stb_o) pstb_cnt++;
        if (width_stb_o) wstb_cnt++;
        if ((period_stb_o && pstb_prev) || (width_stb_o && wstb_prev)) dbl_cnt++;
        pstb_prev = period_stb_o;
        wstb_prev = width_stb_o;
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic pattern(input int hi, input int lo, input int reps);
        for (int k = 0; k < reps; k++) begin
            sig_i = 1'b1;
            cycles(hi);
            sig_i = 1'b0;
            cycles(lo);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int exp_p;
        int exp_w;
        cycles(5);
        // R1 reset state
        check("R1 period", period_o, 0);
        check("R1 width", width_o, 0);
        check("R1 strobes", {period_stb_o, width_stb_o}, 0);
        check("R1 flags", {valid_o, nosig_o, level_o}, 0);
        rst_ni = 1'b1;
        cycles(1);
        check("R1 flags after release", {valid_o, nosig_o, level_o}, 0);

        // R7 stuck low from reset
        cycles(2 * T_STD);
        check("R7 nosig", nosig_o, 1);
        check("R7 level low", level_o, 0);
        check("R7 period zero", period_o, 0);
        check("R7 valid clear", valid_o, 0);

        // R6 arming edge gives no period; width still captured (R3)
        pstb_cnt = 0;
        wstb_cnt = 0;
        pattern(4, 10, 1);
        check("R6 no period strobe", pstb_cnt, 0);
        check("R6 period zero", period_o, 0);
        check("R3 width after arm", width_o, 4);
        check("R3 width strobe count", wstb_cnt, 1);
        check("R5 valid clear while armed", valid_o, 0);
        // R11 first full period recovers
        pattern(4, 10, 1);
        check("R11 period strobe", pstb_cnt, 1);
        check("R11 period", period_o, 14);
        check("R11 nosig cleared", nosig_o, 0);
        check("R11 valid set", valid_o, 1);

        // R2/R3 sweep of high and low times
        for (int h = 1; h <= 6; h++) begin
            for (int l = 1; l <= 6; l++) begin
                pattern(h, l, 4);
                cycles(4);
                check("R2 period sweep", period_o, h + l);
                check("R3 width sweep", width_o, h);
                check("R5 valid sweep", valid_o, 1);
            end
        end
        pattern(17, 3, 3);
        cycles(4);
        check("R2 period 20", period_o, 20);
        check("R3 width 17", width_o, 17);
        pstb_cnt = 0;
        pattern(3, 29, 3);
        cycles(4);
        check("R2 period 32", period_o, 32);
        check("R3 width 3", width_o, 3);
        check("R2 strobe per period", pstb_cnt, 3);

        // R10 saturation with a long timeout
        timeout_i = TMO_W'(600);
        pattern(300, 100, 3);
        cycles(4);
        exp_p = (1 << CNT_W) - 1;
        exp_w = exp_p;
        check("R10 period saturates", period_o, exp_p);
        check("R10 width saturates", width_o, exp_w);
        check("R10 no timeout", nosig_o, 0);

        // R9 period equal to timeout is measured
        timeout_i = TMO_W'(T_STD);
        cycles(2);
        pattern(20, 20, 4);
        sig_i = 1'b1;
        cycles(4);
        check("R9 period at limit", period_o, T_STD);
        check("R9 no timeout at limit", nosig_o, 0);
        check("R9 valid at limit", valid_o, 1);

        // R8 stuck high
        cycles(2 * T_STD);
        check("R8 nosig", nosig_o, 1);
        check("R8 level high", level_o, 1);
        check("R8 period zero", period_o, 0);
        check("R8 width zero", width_o, 0);
        check("R8 valid clear", valid_o, 0);

        // R9 period one beyond timeout never captures
        pstb_cnt = 0;
        pattern(20, 21, 4);
        sig_i = 1'b1;
        cycles(4);
        check("R9 no strobe beyond limit", pstb_cnt, 0);
        check("R9 nosig beyond limit", nosig_o, 1);
        check("R9 valid beyond limit", valid_o, 0);

        // R4 strobes never on consecutive cycles
        check("R4 single-cycle strobes", dbl_cnt, 0);

        finish_run();
    end

endmodule